// File: doc/BRIEF.md
# Status Word and Flag Controller

This block keeps the 16-bit status word of a small processor core together with a one-byte shadow copy of its flags. It executes the single-byte status instructions. These instructions can force, clear or invert the carry, or derive it from the zero flag. They can exchange the live flags with the shadow byte. They can step or load the two-bit register-bank selector, and they can load the three-bit interrupt priority mask. Two more instructions restore either the flag byte or the whole word from a value the stack path supplies.

The core presents one decoded operation per clock with `op_valid`. It also presents an 8-bit immediate and a 16-bit restore value. The new status word and shadow byte appear on the outputs one clock later. In that same clock, `cost_q` reports how many processor cycles the executed instruction is charged. In a clock without an operation, `cost_q` reads 0.

Word layout: bit 7 S, bit 6 Z, bit 4 H, bit 2 V, bit 1 N, bit 0 C, bits 9:8 bank selector, bits 14:12 interrupt mask. All other bits are only changed by a full-word restore.

Top module: `sr_flag_ctrl`

## Requirements
- R1: After reset, the status word reads 0x7000 (interrupt mask 7, all other bits 0). The shadow byte reads 0x00 and `cost_q` reads 0.
- R2: Operation code 1 (carry reset) clears N, V and C and leaves every other bit alone. It costs 2 cycles.
- R3: Operation code 2 (carry set) clears H and N and sets C. It leaves every other bit alone and costs 2 cycles.
- R4: Operation code 3 (carry invert) clears N and inverts C. Operation code 4 (carry from zero) clears N and sets C to the inverse of Z. Both cost 2 cycles and leave all other bits alone.
- R5: Operation code 5 (flag exchange) swaps bits 7:0 of the status word with the shadow byte. Bits 15:8 are left unchanged, and the operation costs 2 cycles.
- R6: Operation code 6 adds 1 to the bank selector in bits 9:8, and operation code 7 subtracts 1. Both wrap modulo 4 (3+1 gives 0, 0-1 gives 3), cost 2 cycles and leave all other bits alone.
- R7: Operation code 8 loads the bank selector from immediate bits 1:0 and costs 2 cycles. Operation code 9 loads the interrupt mask in bits 14:12 from immediate bits 2:0 and costs 5 cycles. Higher immediate bits are ignored.
- R8: Operation code 10 replaces only bits 7:0 with the low byte of `op_load` and costs 4 cycles. Operation code 11 replaces all 16 bits with `op_load` and costs 6 cycles. Neither touches the shadow byte.
- R9: Operation code 0 (no-op) changes nothing and costs 2 cycles. Codes 12 to 15 change nothing and report cost 0. A clock with `op_valid` low changes nothing and reports cost 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this clock |
| op_code | input | 4 | Decoded operation code (0 to 11 defined) |
| op_imm | input | 8 | Immediate byte for bank and mask loads |
| op_load | input | 16 | Restore value from the stack path |
| sr_q | output | 16 | Current status word |
| shadow_q | output | 8 | Current shadow flag byte |
| cost_q | output | 4 | Cycle cost of the operation executed last clock, 0 if none |

## Verification
The bench builds the block with the default reset mask of 7. This makes the mask field of the reset word non-zero, so a mask load of a smaller value is seen as a real change. The bank selector resets to 0, so the directed part can reach the decrement wrap in the first operations and the increment wrap after three steps. A random phase with all sixteen codes, random immediates and random restore words then reaches flag combinations that only a restore can set up. Examples are Z set before carry-from-zero, and non-zero bits outside the named fields that must survive each other operation.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SR_W     = 16;
    localparam int FLAG_W   = 8;
    localparam int BANK_W   = 2;
    localparam int MASK_W   = 3;
    localparam int COST_W   = 4;

    localparam int BANK_LSB = 8;
    localparam int MASK_LSB = 12;

    localparam int F_S = 7;
    localparam int F_Z = 6;
    localparam int F_H = 4;
    localparam int F_V = 2;
    localparam int F_N = 1;
    localparam int F_C = 0;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_CLRC   = 4'd1,
        OP_SETC   = 4'd2,
        OP_INVC   = 4'd3,
        OP_ZTOC   = 4'd4,
        OP_SWAPF  = 4'd5,
        OP_BANKUP = 4'd6,
        OP_BANKDN = 4'd7,
        OP_BANKLD = 4'd8,
        OP_MASKLD = 4'd9,
        OP_RSTF   = 4'd10,
        OP_RSTSR  = 4'd11
    } sr_op_e;

endpackage

// File: rtl/sr_flag_unit.sv
module sr_flag_unit
    import sr_pkg::*;
(
    input  logic              en,
    input  logic [3:0]        op,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [FLAG_W-1:0] shadow_in,
    input  logic [FLAG_W-1:0] restore_lo,
    output logic [FLAG_W-1:0] flags_out,
    output logic [FLAG_W-1:0] shadow_out
);

    always_comb begin
        flags_out  = flags_in;
        shadow_out = shadow_in;
        if (en) begin
            case (op)
                OP_CLRC: begin
                    flags_out[F_N] = 1'b0;
                    flags_out[F_V] = 1'b0;
                    flags_out[F_C] = 1'b0;
                end
                OP_SETC: begin
                    flags_out[F_H] = 1'b0;
                    flags_out[F_N] = 1'b0;
                    flags_out[F_C] = 1'b1;
                end
                OP_INVC: begin
                    flags_out[F_N] = 1'b0;
                    flags_out[F_C] = ~flags_in[F_C];
                end
                OP_ZTOC: begin
                    flags_out[F_N] = 1'b0;
                    flags_out[F_C] = ~flags_in[F_Z];
                end
                OP_SWAPF: begin
                    flags_out  = shadow_in;
                    shadow_out = flags_in;
                end
                OP_RSTF: flags_out = restore_lo;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sr_field_unit.sv
module sr_field_unit
    import sr_pkg::*;
(
    input  logic              en,
    input  logic [3:0]        op,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [MASK_W-1:0] mask_in,
    input  logic [7:0]        imm,
    output logic [BANK_W-1:0] bank_out,
    output logic [MASK_W-1:0] mask_out
);

    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    always_comb begin
        bank_out = bank_in;
        mask_out = mask_in;
        if (en) begin
            case (op)
                OP_BANKUP: bank_out = bank_in + BANK_ONE;
                OP_BANKDN: bank_out = bank_in - BANK_ONE;
                OP_BANKLD: bank_out = imm[BANK_W-1:0];
                OP_MASKLD: mask_out = imm[MASK_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sr_cost_unit.sv
module sr_cost_unit
    import sr_pkg::*;
(
    input  logic              en,
    input  logic [3:0]        op,
    output logic [COST_W-1:0] cost
);

    always_comb begin
        cost = '0;
        if (en) begin
            case (op)
                OP_NOP, OP_CLRC, OP_SETC, OP_INVC, OP_ZTOC,
                OP_SWAPF, OP_BANKUP, OP_BANKDN, OP_BANKLD:
                    cost = COST_W'(2);
                OP_MASKLD: cost = COST_W'(5);
                OP_RSTF:   cost = COST_W'(4);
                OP_RSTSR:  cost = COST_W'(6);
                default:   cost = '0;
            endcase
        end
    end

endmodule

// File: rtl/sr_flag_ctrl.sv
module sr_flag_ctrl
    import sr_pkg::*;
#(
    parameter logic [MASK_W-1:0] RESET_MASK = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [7:0]        op_imm,
    input  logic [SR_W-1:0]   op_load,
    output logic [SR_W-1:0]   sr_q,
    output logic [FLAG_W-1:0] shadow_q,
    output logic [COST_W-1:0] cost_q
);

    localparam logic [SR_W-1:0] SR_RESET =
        SR_W'({RESET_MASK, {MASK_LSB{1'b0}}});

    logic [FLAG_W-1:0] flags_nx, shadow_nx;
    logic [BANK_W-1:0] bank_nx;
    logic [MASK_W-1:0] mask_nx;
    logic [COST_W-1:0] cost_nx;
    logic [SR_W-1:0]   sr_nx;

    sr_flag_unit u_flags (
        .en         (op_valid),
        .op         (op_code),
        .flags_in   (sr_q[FLAG_W-1:0]),
        .shadow_in  (shadow_q),
        .restore_lo (op_load[FLAG_W-1:0]),
        .flags_out  (flags_nx),
        .shadow_out (shadow_nx)
    );

    sr_field_unit u_fields (
        .en       (op_valid),
        .op       (op_code),
        .bank_in  (sr_q[BANK_LSB +: BANK_W]),
        .mask_in  (sr_q[MASK_LSB +: MASK_W]),
        .imm      (op_imm),
        .bank_out (bank_nx),
        .mask_out (mask_nx)
    );

    sr_cost_unit u_cost (
        .en   (op_valid),
        .op   (op_code),
        .cost (cost_nx)
    );

    always_comb begin
        sr_nx = sr_q;
        sr_nx[FLAG_W-1:0]           = flags_nx;
        sr_nx[BANK_LSB +: BANK_W]   = bank_nx;
        sr_nx[MASK_LSB +: MASK_W]   = mask_nx;
        if (op_valid && op_code == OP_RSTSR)
            sr_nx = op_load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= SR_RESET;
            shadow_q <= '0;
            cost_q   <= '0;
        end else begin
            sr_q     <= sr_nx;
            shadow_q <= shadow_nx;
            cost_q   <= cost_nx;
        end
    end

    // R9: idle clocks hold everything and report zero cost
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(sr_q) && $stable(shadow_q) && cost_q == '0);

    // R6: increment wraps modulo 4
    p_bank_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_BANKUP) |=>
            sr_q[BANK_LSB +: BANK_W] == $past(sr_q[BANK_LSB +: BANK_W] + 2'd1)
            && sr_q[SR_W-1:BANK_LSB+BANK_W] == $past(sr_q[SR_W-1:BANK_LSB+BANK_W]));

    // R5: exchange swaps low byte and shadow, keeps high byte
    p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SWAPF) |=>
            sr_q[FLAG_W-1:0] == $past(shadow_q) && shadow_q == $past(sr_q[FLAG_W-1:0])
            && sr_q[SR_W-1:FLAG_W] == $past(sr_q[SR_W-1:FLAG_W]));

    // R3: carry set forces C, clears H and N
    p_setc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SETC) |=>
            sr_q[F_C] && !sr_q[F_N] && !sr_q[F_H] && cost_q == 4'd2);

    // R8: full restore replaces the word and costs six
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RSTSR) |=>
            sr_q == $past(op_load) && $stable(shadow_q) && cost_q == 4'd6);

    // R4: carry from zero loads inverse of Z
    p_ztoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ZTOC) |=>
            sr_q[F_C] == !$past(sr_q[F_Z]) && !sr_q[F_N]);

endmodule

// File: tb/sr_flag_ctrl_test.sv
`timescale 1ns/1ps
module sr_flag_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  op_imm = '0;
    logic [15:0] op_load = '0;
    logic [15:0] sr_q;
    logic [7:0]  shadow_q;
    logic [3:0]  cost_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_sr, m_sh, m_cost;

    always #2.5 clk = ~clk;

    sr_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_imm(op_imm), .op_load(op_load), .sr_q(sr_q),
        .shadow_q(shadow_q), .cost_q(cost_q)
    );

    function automatic string req_of(input bit v, input int code);
        if (!v) return "R9";
        case (code)
            1: return "R2";
            2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            6, 7: return "R6";
            8, 9: return "R7";
            10, 11: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input int code, input int imm, input int ld);
        int t, b;
        m_cost = 0;
        if (!v) return;
        case (code)
            0: m_cost = 2;
            1: begin m_sr = m_sr & ~32'h07; m_cost = 2; end
            2: begin m_sr = (m_sr & ~32'h12) | 1; m_cost = 2; end
            3: begin m_sr = (m_sr & ~32'h03) | ((m_sr & 1) ^ 1); m_cost = 2; end
            4: begin m_sr = (m_sr & ~32'h03) | (((m_sr >> 6) & 1) ^ 1); m_cost = 2; end
            5: begin t = m_sr & 32'hFF; m_sr = (m_sr & 32'hFF00) | m_sh; m_sh = t; m_cost = 2; end
            6: begin b = ((m_sr >> 8) + 1) & 3; m_sr = (m_sr & ~32'h300) | (b << 8); m_cost = 2; end
            7: begin b = ((m_sr >> 8) + 3) & 3; m_sr = (m_sr & ~32'h300) | (b << 8); m_cost = 2; end
            8: begin m_sr = (m_sr & ~32'h300) | ((imm & 3) << 8); m_cost = 2; end
            9: begin m_sr = (m_sr & ~32'h7000) | ((imm & 7) << 12); m_cost = 5; end
            10: begin m_sr = (m_sr & 32'hFF00) | (ld & 32'hFF); m_cost = 4; end
            11: begin m_sr = ld & 32'hFFFF; m_cost = 6; end
            default: m_cost = 0;
        endcase
    endtask

    task automatic step(input bit v, input int code, input int imm, input int ld);
        string r;
        @(negedge clk);
        op_valid = v;
        op_code  = 4'(code);
        op_imm   = 8'(imm);
        op_load  = 16'(ld);
        model(v, code, imm, ld);
        r = req_of(v, code);
        @(posedge clk);
        #1;
        check(r, "status", int'(sr_q), m_sr);
        check(r, "shadow", int'(shadow_q), m_sh);
        check(r, "cost", int'(cost_q), m_cost);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        m_sr = 32'h7000; m_sh = 0; m_cost = 0;
        check("R1", "status", int'(sr_q), 32'h7000);
        check("R1", "shadow", int'(shadow_q), 0);
        check("R1", "cost", int'(cost_q), 0);

        step(1, 7, 0, 0);              // R6 decrement wrap 0 -> 3
        step(1, 6, 0, 0);              // R6 increment wrap 3 -> 0
        step(1, 6, 0, 0);
        step(1, 6, 0, 0);
        step(1, 6, 0, 0);
        step(1, 6, 0, 0);              // R6 wrap again
        step(1, 10, 0, 16'h00D7);      // R8 flag byte restore
        step(1, 1, 0, 0);              // R2
        step(1, 10, 0, 16'h00FF);
        step(1, 2, 0, 0);              // R3
        step(1, 3, 0, 0);              // R4 invert
        step(1, 3, 0, 0);
        step(1, 4, 0, 0);              // R4 Z set -> C 0
        step(1, 10, 0, 16'h0000);
        step(1, 4, 0, 0);              // R4 Z clear -> C 1
        step(1, 10, 0, 16'h00A5);
        step(1, 5, 0, 0);              // R5 swap
        step(1, 5, 0, 0);              // R5 swap back
        step(1, 8, 8'hFE, 0);          // R7 upper bits ignored
        step(1, 9, 8'hFA, 0);          // R7 mask load
        step(1, 11, 0, 16'hBEEF);      // R8 full restore
        step(1, 0, 0, 0);              // R9 nop
        step(1, 13, 8'hFF, 16'hFFFF);  // R9 undefined code
        step(0, 11, 0, 16'h1234);      // R9 not valid
        for (int i = 0; i < 4000; i++)
            step(($urandom % 5) != 0, int'($urandom % 16), int'($urandom % 256),
                 int'($urandom % 65536));
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule